// File: doc/BRIEF.md
# Octagon Node Hop Router

This block makes the forwarding decision for one node of an eight-node octagon interconnect. The nodes form a ring, and each node also has a direct link to the node diametrically opposite it. A packet arrives on a valid/ready handshake, tagged with a 3-bit destination. The block subtracts the node's own 3-bit identity from that destination, modulo 8, and uses the result to pick one of four exits: deliver locally, step clockwise, step counterclockwise, or cross to the opposite node.

The decision is captured in a single-entry output register. That register holds a one-hot direction vector, the identity of the next node, the destination tag and the unchanged payload. The entry is released when the downstream side accepts it. While the entry is occupied and not being drained, the input is stalled. Because of this routing rule, every destination is at most two hops from any source.

Top module: `oct_hop_router`

## Requirements
- R1: When (in_dest − own_id) mod 8 is 0, the accepted packet leaves with out_dir = 4'b0001 (local) and out_next = own_id.
- R2: When the relative address is 1 or 2, out_dir = 4'b0010 (clockwise) and out_next = (own_id + 1) mod 8.
- R3: When the relative address is 6 or 7, out_dir = 4'b0100 (counterclockwise) and out_next = (own_id − 1) mod 8.
- R4: When the relative address is 3, 4 or 5, out_dir = 4'b1000 (across) and out_next = (own_id + 4) mod 8.
- R5: After reset out_valid is 0 and in_ready is 1. Whenever out_valid is 1, exactly one bit of out_dir is set.
- R6: A packet accepted at a clock edge appears on the outputs at that same edge. Its out_data equals the accepted in_data and its out_dest equals the accepted in_dest.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_dir, out_next, out_dest and out_data stay unchanged.
- R8: With out_ready held at 1, in_ready stays 1, so a packet can be accepted on every cycle.
- R9: Following out_next from any source node reaches any destination with local delivery after at most two forwarding hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_id | input | 3 | This node's address |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Router can take a packet |
| in_dest | input | 3 | Destination tag of incoming packet |
| in_data | input | DATA_W | Incoming payload |
| out_valid | output | 1 | Routed packet held |
| out_ready | input | 1 | Downstream takes the held packet |
| out_dir | output | 4 | One-hot exit: bit0 local, bit1 clockwise, bit2 counterclockwise, bit3 across |
| out_next | output | 3 | Identity of the next node |
| out_dest | output | 3 | Destination tag, unchanged |
| out_data | output | DATA_W | Payload, unchanged |

## Verification
A fault in the relative-address decode shows up on out_dir and out_next in the cycle after the packet is accepted. The two-hop walk over all 64 source and destination pairs exposes any misrouted class, because a packet sent the wrong way either does not arrive or needs too many hops. A fault in the occupancy bit shows up as a dropped or duplicated packet, or as in_ready rising while backpressure is applied. Either is visible within one cycle of the stall starting or ending.

// File: rtl/oct_hop_router.sv
module oct_hop_router #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        own_id,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_dest,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_dir,
  output logic [2:0]        out_next,
  output logic [2:0]        out_dest,
  output logic [DATA_W-1:0] out_data
);
  logic [2:0] rel;
  logic [3:0] dir_d;
  logic [2:0] next_d;
  logic       take;

  assign rel      = in_dest - own_id;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    case (rel)
      3'd0:         begin dir_d = 4'b0001; next_d = own_id;         end
      3'd1, 3'd2:   begin dir_d = 4'b0010; next_d = own_id + 3'd1;  end
      3'd6, 3'd7:   begin dir_d = 4'b0100; next_d = own_id - 3'd1;  end
      default:      begin dir_d = 4'b1000; next_d = own_id + 3'd4;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dir   <= '0;
      out_next  <= '0;
      out_dest  <= '0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_dir   <= dir_d;
      out_next  <= next_d;
      out_dest  <= in_dest;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/oct_hop_router_chk.sv
module oct_hop_router_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        own_id,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_dest,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [3:0]        out_dir,
  input logic [2:0]        out_next,
  input logic [2:0]        out_dest,
  input logic [DATA_W-1:0] out_data
);
  p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_dir) == 1);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dir) && $stable(out_next)
                                && $stable(out_dest) && $stable(out_data));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)
                             && out_dest == $past(in_dest));

  p_cw_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dir[1] |-> out_next == own_id + 3'd1);

  p_ccw_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dir[2] |-> out_next == own_id - 3'd1);

  p_across_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dir[3] |-> out_next == own_id + 3'd4);

  p_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dir[0] |-> out_next == own_id && out_dest == own_id);
endmodule

bind oct_hop_router oct_hop_router_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .own_id(own_id), .in_valid(in_valid),
  .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir),
  .out_next(out_next), .out_dest(out_dest), .out_data(out_data)
);

// File: tb/oct_hop_router_tb_top.sv
module oct_hop_router_tb_top;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0;
  logic [2:0] own_id = 0, in_dest = 0;
  logic in_valid = 0, out_ready = 1;
  logic [DW-1:0] in_data = 0;
  logic in_ready, out_valid;
  logic [3:0] out_dir;
  logic [2:0] out_next, out_dest;
  logic [DW-1:0] out_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  oct_hop_router #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .in_valid(in_valid),
    .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir),
    .out_next(out_next), .out_dest(out_dest), .out_data(out_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] expect_route(input logic [2:0] own, input logic [2:0] dst);
    logic [2:0] r = dst - own;
    if (r == 0) return {4'b0001, own};
    if (r == 1 || r == 2) return {4'b0010, 3'(own + 1)};
    if (r == 6 || r == 7) return {4'b0100, 3'(own - 1)};
    return {4'b1000, 3'(own + 4)};
  endfunction

  task automatic query(input logic [2:0] own, input logic [2:0] dst, input logic [DW-1:0] d,
                       output logic [3:0] dir, output logic [2:0] nxt, output logic [DW-1:0] od);
    own_id = own; in_dest = dst; in_data = d; in_valid = 1; out_ready = 1;
    @(negedge clk);
    dir = out_dir; nxt = out_next; od = out_data;
    in_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R5 reset out_valid", 32'(out_valid), 0);
    chk("R5 reset in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_classes;
    logic [3:0] dir; logic [2:0] nxt; logic [DW-1:0] od; logic [6:0] e;
    for (int o = 0; o < 8; o += 3)
      for (int d = 0; d < 8; d++) begin
        e = expect_route(3'(o), 3'(d));
        query(3'(o), 3'(d), 16'(16'hA500 + o * 8 + d), dir, nxt, od);
        case (e[6:3])
          4'b0001: begin chk("R1 dir", 32'(dir), 32'(e[6:3])); chk("R1 next", 32'(nxt), 32'(e[2:0])); end
          4'b0010: begin chk("R2 dir", 32'(dir), 32'(e[6:3])); chk("R2 next", 32'(nxt), 32'(e[2:0])); end
          4'b0100: begin chk("R3 dir", 32'(dir), 32'(e[6:3])); chk("R3 next", 32'(nxt), 32'(e[2:0])); end
          default: begin chk("R4 dir", 32'(dir), 32'(e[6:3])); chk("R4 next", 32'(nxt), 32'(e[2:0])); end
        endcase
        chk("R6 payload", 32'(od), 32'(16'hA500 + o * 8 + d));
        chk("R5 drained", 32'(out_valid), 0);
      end
  endtask

  task automatic t_backpressure;
    own_id = 3'd2; out_ready = 0;
    in_dest = 3'd5; in_data = 16'h1111; in_valid = 1;
    @(negedge clk);
    chk("R6 held data", 32'(out_data), 32'h1111);
    chk("R4 held dir", 32'(out_dir), 32'b1000);
    in_dest = 3'd3; in_data = 16'h2222;
    for (int i = 0; i < 3; i++) begin
      chk("R7 in_ready low", 32'(in_ready), 0);
      chk("R7 data stable", 32'(out_data), 32'h1111);
      chk("R7 next stable", 32'(out_next), 32'd6);
      chk("R7 dest stable", 32'(out_dest), 32'd5);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    chk("R7 second packet", 32'(out_data), 32'h2222);
    chk("R2 second dir", 32'(out_dir), 32'b0010);
    in_valid = 0;
    @(negedge clk);
    chk("R7 drained", 32'(out_valid), 0);
  endtask

  task automatic t_stream;
    own_id = 3'd7; out_ready = 1;
    for (int i = 0; i < 8; i++) begin
      in_dest = 3'(i); in_data = 16'(16'h3000 + i); in_valid = 1;
      chk("R8 in_ready", 32'(in_ready), 1);
      @(negedge clk);
      chk("R8 stream data", 32'(out_data), 32'(16'h3000 + i));
      chk("R8 stream valid", 32'(out_valid), 1);
    end
    in_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_two_hop;
    logic [3:0] dir; logic [2:0] nxt, cur; logic [DW-1:0] od; int hops; bit done;
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++) begin
        cur = 3'(s); hops = 0; done = 0;
        for (int k = 0; k < 4 && !done; k++) begin
          query(cur, 3'(d), 16'h0, dir, nxt, od);
          if (dir == 4'b0001) done = 1;
          else begin cur = nxt; hops++; end
        end
        chk("R9 arrival", {31'(0), done && cur == 3'(d)}, 1);
        chk("R9 hops<=2", {31'(0), hops <= 2}, 1);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_classes();
    t_backpressure();
    t_stream();
    t_two_hop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule